// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block is a small fully associative buffer that turns a virtual page number into a physical page number. Each slot holds a page tag, the physical page, an address-space number, a global flag, one read-enable and one write-enable bit per privilege mode, and a fault-on-read and a fault-on-write flag. The lookup is combinational on stored state: the result for a request appears in the same cycle. It hits when a valid slot carries the requested tag and either its global flag is set or its address-space number equals the requested one.

New mappings go into the slot named by a round-robin replacement pointer. An index port shows the slot under the pointer and can step the pointer on request. Three flush commands remove entries: all entries, only the non-global entries, or the entries that a given page and address space would hit. The block serves as the lookup stage in front of a permission checker and a page-table walker. Both of those sit outside it.

Top module: `asid_xlat_buf`

## Requirements
- R1: A lookup hits only on a valid slot whose tag equals `lk_vpn` and whose global flag is set or whose address-space number equals `lk_asn`. A non-global entry requested with another address-space number misses.
- R2: On a hit, `lk_ppn`, `lk_rd_en`, `lk_wr_en`, `lk_fault_rd` and `lk_fault_wr` carry the stored fields of the hit slot. On a miss they are all zero.
- R3: When several slots match, the result comes from the lowest-numbered matching slot.
- R4: `ins_valid` writes the entry into the slot at `idx_slot` and sets it valid. The pointer then steps by one and wraps from slot ENTRIES-1 to slot 0.
- R5: Inserting into a slot that holds a valid entry replaces that entry. The old tag no longer hits.
- R6: `flush_all` clears every valid flag and returns the pointer to slot 0. It wins over everything else in that cycle, and an insert in the same cycle is dropped.
- R7: `flush_private` clears every entry whose global flag is clear and keeps global entries. It wins over `flush_page`.
- R8: `flush_page` clears every valid slot that a lookup of (`flush_vpn`, `flush_asn`) would hit under the rule of R1. This includes global slots with that tag, whatever their address-space number.
- R9: `idx_valid`, `idx_vpn`, `idx_ppn`, `idx_asn` and `idx_global` show the slot at `idx_slot`. `idx_adv` steps the pointer. `idx_adv` together with `ins_valid` steps it only once.
- R10: A flush or insert takes effect at the next rising clock edge. A lookup in the same cycle sees the state from before the command.
- R11: After reset no slot is valid and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Lookup address-space number |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page on hit |
| lk_rd_en | output | MODES | Per-mode read enables on hit |
| lk_wr_en | output | MODES | Per-mode write enables on hit |
| lk_fault_rd | output | 1 | Fault-on-read flag on hit |
| lk_fault_wr | output | 1 | Fault-on-write flag on hit |
| ins_valid | input | 1 | Insert strobe |
| ins_vpn | input | VPN_W | Inserted tag |
| ins_ppn | input | PPN_W | Inserted physical page |
| ins_asn | input | ASN_W | Inserted address-space number |
| ins_global | input | 1 | Inserted global flag |
| ins_rd_en | input | MODES | Inserted read enables |
| ins_wr_en | input | MODES | Inserted write enables |
| ins_fault_rd | input | 1 | Inserted fault-on-read flag |
| ins_fault_wr | input | 1 | Inserted fault-on-write flag |
| flush_all | input | 1 | Invalidate every slot |
| flush_private | input | 1 | Invalidate non-global slots |
| flush_page | input | 1 | Invalidate slots matching page and address space |
| flush_vpn | input | VPN_W | Page for flush_page |
| flush_asn | input | ASN_W | Address space for flush_page |
| idx_adv | input | 1 | Step the replacement pointer |
| idx_slot | output | PW | Replacement pointer |
| idx_valid | output | 1 | Valid flag of slot at pointer |
| idx_vpn | output | VPN_W | Tag of slot at pointer |
| idx_ppn | output | PPN_W | Physical page of slot at pointer |
| idx_asn | output | ASN_W | Address-space number of slot at pointer |
| idx_global | output | 1 | Global flag of slot at pointer |

## Verification
The hardest state to reach from the ports is a buffer holding duplicate tags, wrapped pointer positions and a mix of global and private entries. The stimulus builds it in steps. It inserts the same page twice so that two slots match. It fills the buffer past its last slot so that the pointer wraps onto a slot that is still valid. It then issues flushes while a lookup runs in the same cycle, and an insert during `flush_all`. A reference model in the bench tracks every slot and the pointer. It supplies the expected result of each lookup and index read, and the scoreboard compares them in the same cycle.

// File: rtl/xlat_pkg.sv
// Shared types for the translation buffer.
// Assumes: at most one flush kind is applied per cycle, chosen by priority.
package xlat_pkg;

    typedef enum logic [1:0] {
        INV_NONE    = 2'd0,
        INV_ALL     = 2'd1,
        INV_PRIVATE = 2'd2,
        INV_PAGE    = 2'd3
    } inv_op_e;

    // Priority: everything > non-global > by page.
    function automatic inv_op_e pick_inv(input logic all, input logic priv, input logic page);
        if (all)       return INV_ALL;
        else if (priv) return INV_PRIVATE;
        else if (page) return INV_PAGE;
        else           return INV_NONE;
    endfunction

    // Address-space rule shared by lookup and page flush.
    function automatic logic space_ok(input logic glob, input logic asn_eq);
        return glob | asn_eq;
    endfunction

endpackage

// File: rtl/xlat_repl_ptr.sv
// Round-robin replacement pointer.
// Assumes: clr has priority over adv; adv steps by exactly one slot and wraps.
module xlat_repl_ptr #(
    parameter  int ENTRIES = 8,
    localparam int PW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          adv,
    output logic [PW-1:0] ptr
);
    localparam logic [PW-1:0] LAST = PW'(ENTRIES - 1);

    // Pointer update: clear, step, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)      ptr <= '0;
        else if (clr)    ptr <= '0;
        else if (adv)    ptr <= (ptr == LAST) ? '0 : ptr + PW'(1);
    end

    // R4
    ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && ptr == LAST) |=> (ptr == '0));
    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && ptr != LAST) |=> (ptr == $past(ptr) + PW'(1)));
    // R6
    ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ptr == '0));
    // R9
    ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(ptr));

endmodule

// File: rtl/xlat_store.sv
// Slot storage with valid flags, flush decoding and insert write port.
// Assumes: the caller suppresses ins_en when the operation is INV_ALL; an
// insert into a slot wins over a flush of that same slot.
module xlat_store
    import xlat_pkg::*;
#(
    parameter  int ENTRIES = 8,
    parameter  int VPN_W   = 20,
    parameter  int PPN_W   = 16,
    parameter  int ASN_W   = 8,
    parameter  int MODES   = 4,
    localparam int PW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  inv_op_e            op,
    input  logic [VPN_W-1:0]   inv_vpn,
    input  logic [ASN_W-1:0]   inv_asn,
    input  logic               ins_en,
    input  logic [PW-1:0]      ins_slot,
    input  logic [VPN_W-1:0]   ins_vpn,
    input  logic [PPN_W-1:0]   ins_ppn,
    input  logic [ASN_W-1:0]   ins_asn,
    input  logic               ins_glob,
    input  logic [MODES-1:0]   ins_rd,
    input  logic [MODES-1:0]   ins_wr,
    input  logic               ins_frd,
    input  logic               ins_fwr,
    output logic [ENTRIES-1:0] valid_q,
    output logic [ENTRIES-1:0] glob_q,
    output logic [ENTRIES-1:0] frd_q,
    output logic [ENTRIES-1:0] fwr_q,
    output logic [VPN_W-1:0]   vpn_q [ENTRIES],
    output logic [PPN_W-1:0]   ppn_q [ENTRIES],
    output logic [ASN_W-1:0]   asn_q [ENTRIES],
    output logic [MODES-1:0]   rd_q  [ENTRIES],
    output logic [MODES-1:0]   wr_q  [ENTRIES]
);
    logic [ENTRIES-1:0] kill;

    // Per-slot kill decision for the selected flush.
    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            unique case (op)
                INV_ALL:     kill[i] = 1'b1;
                INV_PRIVATE: kill[i] = !glob_q[i];
                INV_PAGE:    kill[i] = valid_q[i] && (vpn_q[i] == inv_vpn) &&
                                       space_ok(glob_q[i], asn_q[i] == inv_asn);
                default:     kill[i] = 1'b0;
            endcase
        end
    end

    // Slot registers: insert write, else flush clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            glob_q  <= '0;
            frd_q   <= '0;
            fwr_q   <= '0;
            for (int i = 0; i < ENTRIES; i++) begin
                vpn_q[i] <= '0;
                ppn_q[i] <= '0;
                asn_q[i] <= '0;
                rd_q[i]  <= '0;
                wr_q[i]  <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                if (ins_en && ins_slot == PW'(i)) begin
                    valid_q[i] <= 1'b1;
                    glob_q[i]  <= ins_glob;
                    frd_q[i]   <= ins_frd;
                    fwr_q[i]   <= ins_fwr;
                    vpn_q[i]   <= ins_vpn;
                    ppn_q[i]   <= ins_ppn;
                    asn_q[i]   <= ins_asn;
                    rd_q[i]    <= ins_rd;
                    wr_q[i]    <= ins_wr;
                end else if (kill[i]) begin
                    valid_q[i] <= 1'b0;
                end
            end
        end
    end

    // R7
    private_gone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == INV_PRIVATE && !ins_en) |=> ((valid_q & ~glob_q) == '0));
    // R7
    global_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == INV_PRIVATE && !ins_en) |=> (valid_q == $past(valid_q & glob_q)));
    // R8
    page_no_new_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == INV_PAGE && !ins_en) |=> ((valid_q & ~$past(valid_q)) == '0));
    // R4
    ins_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |=> valid_q[$past(ins_slot)]);

endmodule

// File: rtl/xlat_lookup.sv
// Combinational associative match with lowest-index priority.
// Assumes: stored fields are stable within a cycle; outputs are zero on miss.
module xlat_lookup
    import xlat_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PPN_W   = 16,
    parameter int ASN_W   = 8,
    parameter int MODES   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [VPN_W-1:0]   req_vpn,
    input  logic [ASN_W-1:0]   req_asn,
    input  logic [ENTRIES-1:0] valid_q,
    input  logic [ENTRIES-1:0] glob_q,
    input  logic [ENTRIES-1:0] frd_q,
    input  logic [ENTRIES-1:0] fwr_q,
    input  logic [VPN_W-1:0]   vpn_q [ENTRIES],
    input  logic [PPN_W-1:0]   ppn_q [ENTRIES],
    input  logic [ASN_W-1:0]   asn_q [ENTRIES],
    input  logic [MODES-1:0]   rd_q  [ENTRIES],
    input  logic [MODES-1:0]   wr_q  [ENTRIES],
    output logic               hit,
    output logic [PPN_W-1:0]   ppn,
    output logic [MODES-1:0]   rd_en,
    output logic [MODES-1:0]   wr_en,
    output logic               f_rd,
    output logic               f_wr
);
    // Scan high to low so the lowest matching slot is written last and wins.
    always_comb begin
        hit   = 1'b0;
        ppn   = '0;
        rd_en = '0;
        wr_en = '0;
        f_rd  = 1'b0;
        f_wr  = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (valid_q[i] && vpn_q[i] == req_vpn &&
                space_ok(glob_q[i], asn_q[i] == req_asn)) begin
                hit   = 1'b1;
                ppn   = ppn_q[i];
                rd_en = rd_q[i];
                wr_en = wr_q[i];
                f_rd  = frd_q[i];
                f_wr  = fwr_q[i];
            end
        end
    end

    // R1
    hit_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (valid_q != '0));

endmodule

// File: rtl/asid_xlat_buf.sv
// Address-space-tagged translation buffer top.
// Assumes: flush_all > flush_private > flush_page in one cycle; an insert is
// dropped under flush_all; insert and idx_adv together step the pointer once.
module asid_xlat_buf
    import xlat_pkg::*;
#(
    parameter  int ENTRIES = 8,
    parameter  int VPN_W   = 20,
    parameter  int PPN_W   = 16,
    parameter  int ASN_W   = 8,
    parameter  int MODES   = 4,
    localparam int PW      = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [ASN_W-1:0] lk_asn,
    output logic             lk_hit,
    output logic [PPN_W-1:0] lk_ppn,
    output logic [MODES-1:0] lk_rd_en,
    output logic [MODES-1:0] lk_wr_en,
    output logic             lk_fault_rd,
    output logic             lk_fault_wr,
    input  logic             ins_valid,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_ppn,
    input  logic [ASN_W-1:0] ins_asn,
    input  logic             ins_global,
    input  logic [MODES-1:0] ins_rd_en,
    input  logic [MODES-1:0] ins_wr_en,
    input  logic             ins_fault_rd,
    input  logic             ins_fault_wr,
    input  logic             flush_all,
    input  logic             flush_private,
    input  logic             flush_page,
    input  logic [VPN_W-1:0] flush_vpn,
    input  logic [ASN_W-1:0] flush_asn,
    input  logic             idx_adv,
    output logic [PW-1:0]    idx_slot,
    output logic             idx_valid,
    output logic [VPN_W-1:0] idx_vpn,
    output logic [PPN_W-1:0] idx_ppn,
    output logic [ASN_W-1:0] idx_asn,
    output logic             idx_global
);
    inv_op_e            op;
    logic               ins_en;
    logic [ENTRIES-1:0] valid_q, glob_q, frd_q, fwr_q;
    logic [VPN_W-1:0]   vpn_q [ENTRIES];
    logic [PPN_W-1:0]   ppn_q [ENTRIES];
    logic [ASN_W-1:0]   asn_q [ENTRIES];
    logic [MODES-1:0]   rd_q  [ENTRIES];
    logic [MODES-1:0]   wr_q  [ENTRIES];

    // Command decode: flush priority and insert suppression.
    always_comb begin
        op     = pick_inv(flush_all, flush_private, flush_page);
        ins_en = ins_valid && (op != INV_ALL);
    end

    xlat_repl_ptr #(.ENTRIES(ENTRIES)) u_ptr (
        .clk (clk),
        .rst_n (rst_n),
        .clr (flush_all),
        .adv (ins_valid | idx_adv),
        .ptr (idx_slot)
    );

    xlat_store #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .MODES(MODES)
    ) u_store (
        .clk (clk), .rst_n (rst_n), .op (op),
        .inv_vpn (flush_vpn), .inv_asn (flush_asn),
        .ins_en (ins_en), .ins_slot (idx_slot),
        .ins_vpn (ins_vpn), .ins_ppn (ins_ppn), .ins_asn (ins_asn),
        .ins_glob (ins_global), .ins_rd (ins_rd_en), .ins_wr (ins_wr_en),
        .ins_frd (ins_fault_rd), .ins_fwr (ins_fault_wr),
        .valid_q (valid_q), .glob_q (glob_q), .frd_q (frd_q), .fwr_q (fwr_q),
        .vpn_q (vpn_q), .ppn_q (ppn_q), .asn_q (asn_q), .rd_q (rd_q), .wr_q (wr_q)
    );

    xlat_lookup #(
        .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W), .MODES(MODES)
    ) u_lookup (
        .clk (clk), .rst_n (rst_n),
        .req_vpn (lk_vpn), .req_asn (lk_asn),
        .valid_q (valid_q), .glob_q (glob_q), .frd_q (frd_q), .fwr_q (fwr_q),
        .vpn_q (vpn_q), .ppn_q (ppn_q), .asn_q (asn_q), .rd_q (rd_q), .wr_q (wr_q),
        .hit (lk_hit), .ppn (lk_ppn), .rd_en (lk_rd_en), .wr_en (lk_wr_en),
        .f_rd (lk_fault_rd), .f_wr (lk_fault_wr)
    );

    // Index port: view of the slot under the replacement pointer.
    always_comb begin
        idx_valid  = valid_q[idx_slot];
        idx_vpn    = vpn_q[idx_slot];
        idx_ppn    = ppn_q[idx_slot];
        idx_asn    = asn_q[idx_slot];
        idx_global = glob_q[idx_slot];
    end

    // R6
    flush_all_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid_q == '0));
    // R11
    reset_empty_chk: assert property (@(posedge clk)
        !rst_n |=> (valid_q == '0 && idx_slot == '0));

endmodule

// File: tb/asid_xlat_buf_tb.sv
`timescale 1ns/1ps
module asid_xlat_buf_tb;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [19:0] lk_vpn = '0;  logic [7:0] lk_asn = '0;
    logic lk_hit; logic [15:0] lk_ppn; logic [3:0] lk_rd_en, lk_wr_en;
    logic lk_fault_rd, lk_fault_wr;
    logic ins_valid = 0; logic [19:0] ins_vpn = '0; logic [15:0] ins_ppn = '0;
    logic [7:0] ins_asn = '0; logic ins_global = 0;
    logic [3:0] ins_rd_en = '0, ins_wr_en = '0; logic ins_fault_rd = 0, ins_fault_wr = 0;
    logic flush_all = 0, flush_private = 0, flush_page = 0;
    logic [19:0] flush_vpn = '0; logic [7:0] flush_asn = '0;
    logic idx_adv = 0;
    logic [2:0] idx_slot; logic idx_valid; logic [19:0] idx_vpn;
    logic [15:0] idx_ppn; logic [7:0] idx_asn; logic idx_global;

    asid_xlat_buf u_dut (
        .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn),
        .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_rd_en(lk_rd_en), .lk_wr_en(lk_wr_en),
        .lk_fault_rd(lk_fault_rd), .lk_fault_wr(lk_fault_wr),
        .ins_valid(ins_valid), .ins_vpn(ins_vpn), .ins_ppn(ins_ppn), .ins_asn(ins_asn),
        .ins_global(ins_global), .ins_rd_en(ins_rd_en), .ins_wr_en(ins_wr_en),
        .ins_fault_rd(ins_fault_rd), .ins_fault_wr(ins_fault_wr),
        .flush_all(flush_all), .flush_private(flush_private), .flush_page(flush_page),
        .flush_vpn(flush_vpn), .flush_asn(flush_asn), .idx_adv(idx_adv),
        .idx_slot(idx_slot), .idx_valid(idx_valid), .idx_vpn(idx_vpn),
        .idx_ppn(idx_ppn), .idx_asn(idx_asn), .idx_global(idx_global)
    );

    // Reference model of the slots.
    bit          m_v [N]; bit m_g [N]; bit m_fr [N]; bit m_fw [N];
    logic [19:0] m_vpn [N]; logic [15:0] m_ppn [N]; logic [7:0] m_asn [N];
    logic [3:0]  m_rd [N]; logic [3:0] m_wr [N];
    int          m_ptr = 0;

    typedef struct {
        int kind; string req;
        logic hit; logic [15:0] ppn; logic [3:0] rd, wr; logic fr, fw;
        logic [2:0] ptr; logic iv; logic [19:0] ivpn;
    } exp_t;
    exp_t sb[$];

    int checks = 0, failures = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int model_find(input logic [19:0] vpn, input logic [7:0] asn);
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asn[i] == asn)) return i;
        return -1;
    endfunction

    task automatic begin_cycle();
        @(posedge clk); #1;
        ins_valid = 0; flush_all = 0; flush_private = 0; flush_page = 0; idx_adv = 0;
    endtask

    task automatic set_ins(input logic [19:0] vpn, input logic [15:0] ppn,
                           input logic [7:0] asn, input bit g, input logic [3:0] rd,
                           input logic [3:0] wr, input bit fr, input bit fw);
        ins_valid = 1; ins_vpn = vpn; ins_ppn = ppn; ins_asn = asn; ins_global = g;
        ins_rd_en = rd; ins_wr_en = wr; ins_fault_rd = fr; ins_fault_wr = fw;
    endtask

    // Driver: apply a lookup and push its expected result.
    task automatic look(input logic [19:0] vpn, input logic [7:0] asn, input string req);
        exp_t e; int k;
        lk_vpn = vpn; lk_asn = asn;
        k = model_find(vpn, asn);
        e.kind = 0; e.req = req; e.ptr = '0; e.iv = 0; e.ivpn = '0;
        if (k >= 0) begin
            e.hit = 1; e.ppn = m_ppn[k]; e.rd = m_rd[k]; e.wr = m_wr[k];
            e.fr = m_fr[k]; e.fw = m_fw[k];
        end else begin
            e.hit = 0; e.ppn = '0; e.rd = '0; e.wr = '0; e.fr = 0; e.fw = 0;
        end
        sb.push_back(e);
    endtask

    task automatic peek_idx(input string req);
        exp_t e;
        e.kind = 1; e.req = req; e.hit = 0; e.ppn = '0; e.rd = '0; e.wr = '0;
        e.fr = 0; e.fw = 0;
        e.ptr = 3'(m_ptr); e.iv = m_v[m_ptr]; e.ivpn = m_vpn[m_ptr];
        sb.push_back(e);
    endtask

    // Advance the model by the commands driven this cycle.
    task automatic end_cycle();
        if (flush_all) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
            m_ptr = 0;
        end else begin
            for (int i = 0; i < N; i++) begin
                if (flush_private) begin
                    if (!m_g[i]) m_v[i] = 0;
                end else if (flush_page && m_v[i] && m_vpn[i] == flush_vpn &&
                             (m_g[i] || m_asn[i] == flush_asn)) m_v[i] = 0;
            end
            if (ins_valid) begin
                m_v[m_ptr] = 1; m_g[m_ptr] = ins_global; m_fr[m_ptr] = ins_fault_rd;
                m_fw[m_ptr] = ins_fault_wr; m_vpn[m_ptr] = ins_vpn; m_ppn[m_ptr] = ins_ppn;
                m_asn[m_ptr] = ins_asn; m_rd[m_ptr] = ins_rd_en; m_wr[m_ptr] = ins_wr_en;
            end
            if (ins_valid || idx_adv) m_ptr = (m_ptr + 1) % N;
        end
    endtask

    task automatic do_ins(input logic [19:0] vpn, input logic [15:0] ppn,
                          input logic [7:0] asn, input bit g, input logic [3:0] rd,
                          input logic [3:0] wr, input bit fr, input bit fw);
        begin_cycle(); set_ins(vpn, ppn, asn, g, rd, wr, fr, fw); end_cycle();
    endtask

    task automatic do_look(input logic [19:0] vpn, input logic [7:0] asn, input string req);
        begin_cycle(); look(vpn, asn, req); end_cycle();
    endtask

    // Monitor: compare every pending item at the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                if (e.kind == 0) begin
                    chk(lk_hit == e.hit, e.req, "lk_hit", 32'(lk_hit), 32'(e.hit));
                    chk(lk_ppn == e.ppn, e.req, "lk_ppn", 32'(lk_ppn), 32'(e.ppn));
                    chk({lk_rd_en, lk_wr_en, lk_fault_rd, lk_fault_wr} ==
                        {e.rd, e.wr, e.fr, e.fw}, e.req, "perm",
                        32'({lk_rd_en, lk_wr_en, lk_fault_rd, lk_fault_wr}),
                        32'({e.rd, e.wr, e.fr, e.fw}));
                end else begin
                    chk(idx_slot == e.ptr, e.req, "idx_slot", 32'(idx_slot), 32'(e.ptr));
                    chk(idx_valid == e.iv, e.req, "idx_valid", 32'(idx_valid), 32'(e.iv));
                    if (e.iv)
                        chk(idx_vpn == e.ivpn, e.req, "idx_vpn", 32'(idx_vpn), 32'(e.ivpn));
                end
            end
        end
    end

    initial begin
        #500000;
        if (!done) begin
            failures++; checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_v[i] = 0; m_g[i] = 0; m_fr[i] = 0; m_fw[i] = 0; m_vpn[i] = '0;
            m_ppn[i] = '0; m_asn[i] = '0; m_rd[i] = '0; m_wr[i] = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R11 reset state
        begin_cycle(); look(20'h0, 8'h0, "R11"); peek_idx("R11"); end_cycle();

        // R4 R1 R2 basic inserts and lookups
        do_ins(20'h100, 16'h0A1, 8'd5, 0, 4'b0011, 4'b0001, 0, 1);
        do_ins(20'h200, 16'h0B2, 8'd7, 1, 4'b1111, 4'b0000, 1, 0);
        do_ins(20'h300, 16'h0C3, 8'd5, 0, 4'b0101, 4'b0100, 0, 0);
        begin_cycle(); peek_idx("R4"); end_cycle();
        do_look(20'h100, 8'd5, "R2");
        do_look(20'h100, 8'd6, "R1");
        do_look(20'h200, 8'd3, "R1");
        do_look(20'h300, 8'd5, "R2");

        // R3 duplicate tag: lowest slot wins
        do_ins(20'h100, 16'h0D4, 8'd5, 0, 4'b1000, 4'b1000, 1, 1);
        do_look(20'h100, 8'd5, "R3");

        // R8 page flush clears both duplicates and a global with other asn
        begin_cycle(); flush_page = 1; flush_vpn = 20'h100; flush_asn = 8'd5; end_cycle();
        do_look(20'h100, 8'd5, "R8");
        begin_cycle(); flush_page = 1; flush_vpn = 20'h200; flush_asn = 8'd9; end_cycle();
        do_look(20'h200, 8'd7, "R8");
        do_look(20'h300, 8'd5, "R8");

        // R4 wrap, R5 replacement
        do_ins(20'h400, 16'h140, 8'd2, 0, 4'b0001, 4'b0001, 0, 0);
        do_ins(20'h401, 16'h141, 8'd2, 1, 4'b0010, 4'b0010, 0, 0);
        do_ins(20'h402, 16'h142, 8'd2, 0, 4'b0100, 4'b0100, 0, 0);
        do_ins(20'h403, 16'h143, 8'd2, 1, 4'b1000, 4'b1000, 1, 1);
        begin_cycle(); peek_idx("R4"); end_cycle();
        do_ins(20'h500, 16'h150, 8'd1, 0, 4'b0001, 4'b0000, 0, 0);
        do_ins(20'h501, 16'h151, 8'd1, 0, 4'b0001, 4'b0000, 0, 0);
        do_ins(20'h502, 16'h152, 8'd1, 0, 4'b0011, 4'b0010, 1, 0);
        do_look(20'h300, 8'd5, "R5");
        do_look(20'h502, 8'd1, "R5");

        // R10 lookup sees pre-flush state; R7 non-global flush
        begin_cycle(); flush_private = 1; flush_page = 1; flush_vpn = 20'h401;
        flush_asn = 8'd2; look(20'h400, 8'd2, "R10"); end_cycle();
        do_look(20'h400, 8'd2, "R7");
        do_look(20'h401, 8'd9, "R7");
        do_look(20'h500, 8'd1, "R7");
        do_look(20'h403, 8'd2, "R7");

        // R9 index port and pointer stepping
        begin_cycle(); idx_adv = 1; end_cycle();
        begin_cycle(); peek_idx("R9"); idx_adv = 1; end_cycle();
        begin_cycle(); peek_idx("R9"); end_cycle();
        begin_cycle(); set_ins(20'h600, 16'h160, 8'd3, 0, 4'b0110, 4'b0010, 0, 1);
        idx_adv = 1; end_cycle();
        begin_cycle(); peek_idx("R9"); look(20'h600, 8'd3, "R9"); end_cycle();
        do_look(20'h401, 8'd9, "R5");

        // R6 flush_all with insert dropped; R10 same-cycle lookup
        begin_cycle(); flush_all = 1;
        set_ins(20'h777, 16'h177, 8'd4, 1, 4'b1111, 4'b1111, 0, 0);
        look(20'h403, 8'd2, "R10"); end_cycle();
        begin_cycle(); look(20'h403, 8'd2, "R6"); peek_idx("R6"); end_cycle();
        do_look(20'h777, 8'd4, "R6");

        // R4 insert after flush_all lands in slot 0
        do_ins(20'h888, 16'h188, 8'd4, 0, 4'b0011, 4'b0011, 0, 0);
        begin_cycle(); peek_idx("R4"); look(20'h888, 8'd4, "R4"); end_cycle();

        repeat (3) @(posedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule